// File: doc/BRIEF.md
# Shared GPIO Port Line Resolver

This block models one general-purpose I/O port whose pins can be driven from two sides. The processor side owns a control register, which holds a direction bit and a pull-up enable bit for every pin, and a data latch. An external peripheral drives its own direction and data masks straight into the block. The block merges both drivers and the pull-ups into the levels the pins actually show. It returns those merged levels whenever the processor reads the data register.

Each processor write to the control register or to the data latch is checked for its effect on the pins. The block compares the pin levels just before the write with the levels that result from it. If any pin moved, it presents the set of changed pins for one cycle. In that same cycle it pulses a notify line for every subscriber whose trigger mask covers at least one changed pin, and it holds the new pin levels on a separate output for the subscribers to read.

Top module: `gpio_port_resolver`

## Requirements
- R1: For pin n, control register bit 2n enables the processor output driver and bit 2n+1 enables the pull-up. A pull-up alone raises an otherwise undriven pin.
- R2: A pin is high when the processor drives it with a 1 in its data latch, or when the peripheral drives it with a 1, or when its pull-up is on and neither side drives it. Otherwise the pin is low.
- R3: `lineLevel` (the data register read value) always shows the resolved pin levels, never the raw data latch contents.
- R4: A write to either register presents `changeMask` = new levels XOR old levels in the cycle after the write edge, for that single cycle only. Here, old levels are the levels just before the write.
- R5: A write that leaves every pin level unchanged produces a zero `changeMask` and no notify pulse.
- R6: Subscriber i (trigger mask at bits [16i+15:16i] of `trigMask`) gets a one-cycle `notify[i]` pulse exactly when its mask ANDed with `changeMask` is nonzero.
- R7: When a change is presented, `notifyLines` carries the pin levels that result from the write, and it holds that value until the next change.
- R8: Reset clears the control register and the data latch. All pins become inputs without pull-up, so they read 0 unless the peripheral drives them, and no change is presented.
- R9: A change of the peripheral masks alone updates `lineLevel` at once but produces no change mask and no notify pulse.
- R10: When both registers are written in the same cycle, both updates apply and a single comparison is made between the levels before and after both updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 32 | Control value: bit 2n direction, bit 2n+1 pull-up |
| dataWrEn | input | 1 | Write strobe for the data latch |
| dataWrData | input | 16 | Data latch value |
| periphDir | input | 16 | Peripheral output enables, one per pin |
| periphData | input | 16 | Peripheral output values |
| trigMask | input | 64 | Trigger masks, 16 bits per subscriber |
| lineLevel | output | 16 | Resolved pin levels, data register read value |
| changeMask | output | 16 | Pins changed by the last write, one cycle |
| notify | output | 4 | One-cycle notify pulse per subscriber |
| notifyLines | output | 16 | Pin levels after the last change |

## Verification
Several properties are checked on every cycle. A peripheral driving a 1 always shows as a high pin. A nonzero change mask or a notify pulse only ever follows a write. XORing the change mask onto the reported levels must give back the levels seen in the cycle before. A notify pulse never appears without a change. The bench scenarios are needed to show the rest, because it depends on particular register values: the interleaved bit decoding, the latch being hidden on reads, the per-subscriber selection, the silence of peripheral-only changes, and the merging of simultaneous writes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef struct packed {
    logic ctrlLoad;
    logic dataLoad;
    logic evalChange;
  } gpioStrobes_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic         ctrlWrEn,
  input  logic         dataWrEn,
  output gpioStrobes_t strobes
);
  // Any register write triggers one before/after comparison.
  always_comb begin
    strobes.ctrlLoad   = ctrlWrEn;
    strobes.dataLoad   = dataWrEn;
    strobes.evalChange = ctrlWrEn | dataWrEn;
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobes_t      strobes,
  input  logic [2*PINS-1:0] ctrlWrData,
  input  logic [PINS-1:0]   dataWrData,
  input  logic [PINS-1:0]   periphDir,
  input  logic [PINS-1:0]   periphData,
  output logic [PINS-1:0]   lineLevel,
  output logic [PINS-1:0]   changeMask,
  output logic              changeValid,
  output logic [PINS-1:0]   notifyLines
);
  localparam int CTRL_W = 2 * PINS;

  logic [CTRL_W-1:0] ctrlReg, ctrlNext;
  logic [PINS-1:0]   dataLatch, dataNext;
  logic [PINS-1:0]   cpuDir, cpuPull, nextDir, nextPull;
  logic [PINS-1:0]   newLines, diffLines;

  assign ctrlNext = strobes.ctrlLoad ? ctrlWrData : ctrlReg;
  assign dataNext = strobes.dataLoad ? dataWrData : dataLatch;

  // Split the interleaved control word into per-pin fields.
  for (genvar n = 0; n < PINS; n++) begin : g_split
    assign cpuDir[n]   = ctrlReg[2*n];
    assign cpuPull[n]  = ctrlReg[2*n+1];
    assign nextDir[n]  = ctrlNext[2*n];
    assign nextPull[n] = ctrlNext[2*n+1];
  end

  function automatic logic [PINS-1:0] resolveLines(
    input logic [PINS-1:0] dir, input logic [PINS-1:0] dat,
    input logic [PINS-1:0] pull,
    input logic [PINS-1:0] pDir, input logic [PINS-1:0] pDat);
    return (dir & dat) | (pDir & pDat) | (pull & ~(dir | pDir));
  endfunction

  assign lineLevel = resolveLines(cpuDir, dataLatch, cpuPull, periphDir, periphData);
  assign newLines  = resolveLines(nextDir, dataNext, nextPull, periphDir, periphData);
  assign diffLines = newLines ^ lineLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      dataLatch   <= '0;
      changeMask  <= '0;
      changeValid <= 1'b0;
      notifyLines <= '0;
    end else begin
      ctrlReg   <= ctrlNext;
      dataLatch <= dataNext;
      if (strobes.evalChange && (diffLines != '0)) begin
        changeMask  <= diffLines;
        changeValid <= 1'b1;
        notifyLines <= newLines;
      end else begin
        changeMask  <= '0;
        changeValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_port_notifier.sv
module gpio_port_notifier #(
  parameter int PINS = 16,
  parameter int SUBS = 4
) (
  input  logic [SUBS*PINS-1:0] trigMask,
  input  logic [PINS-1:0]      changeMask,
  input  logic                 changeValid,
  output logic [SUBS-1:0]      notify
);
  for (genvar i = 0; i < SUBS; i++) begin : g_sub
    assign notify[i] = changeValid && ((trigMask[i*PINS +: PINS] & changeMask) != '0);
  end
endmodule

// File: rtl/gpio_port_resolver.sv
module gpio_port_resolver
  import gpio_port_pkg::*;
#(
  parameter int PINS = 16,
  parameter int SUBS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWrEn,
  input  logic [2*PINS-1:0]    ctrlWrData,
  input  logic                 dataWrEn,
  input  logic [PINS-1:0]      dataWrData,
  input  logic [PINS-1:0]      periphDir,
  input  logic [PINS-1:0]      periphData,
  input  logic [SUBS*PINS-1:0] trigMask,
  output logic [PINS-1:0]      lineLevel,
  output logic [PINS-1:0]      changeMask,
  output logic [SUBS-1:0]      notify,
  output logic [PINS-1:0]      notifyLines
);
  gpioStrobes_t strobes;
  logic         changeValid;

  gpio_port_ctrl u_ctrl (
    .ctrlWrEn (ctrlWrEn),
    .dataWrEn (dataWrEn),
    .strobes  (strobes)
  );

  gpio_port_datapath #(.PINS(PINS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .ctrlWrData  (ctrlWrData),
    .dataWrData  (dataWrData),
    .periphDir   (periphDir),
    .periphData  (periphData),
    .lineLevel   (lineLevel),
    .changeMask  (changeMask),
    .changeValid (changeValid),
    .notifyLines (notifyLines)
  );

  gpio_port_notifier #(.PINS(PINS), .SUBS(SUBS)) u_notify (
    .trigMask    (trigMask),
    .changeMask  (changeMask),
    .changeValid (changeValid),
    .notify      (notify)
  );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int PINS = 16,
  parameter int SUBS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ctrlWrEn,
  input logic                 dataWrEn,
  input logic [PINS-1:0]      periphDir,
  input logic [PINS-1:0]      periphData,
  input logic [PINS-1:0]      lineLevel,
  input logic [PINS-1:0]      changeMask,
  input logic [SUBS-1:0]      notify,
  input logic [PINS-1:0]      notifyLines
);
  // R2: a peripheral driving a 1 always yields a high pin
  p_periph_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((periphDir & periphData) & ~lineLevel) == '0);

  // R4 / R9: a change is only presented after a register write
  p_change_after_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (changeMask != '0) |-> $past(ctrlWrEn || dataWrEn));

  // R4 / R7: change mask relates the reported levels to the previous levels
  p_old_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    (changeMask != '0) |-> ((notifyLines ^ changeMask) == $past(lineLevel)));

  // R5: no notify without a change
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (changeMask == '0) |-> (notify == '0));

  // R6: notify pulses only follow writes
  p_notify_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (notify != '0) |-> $past(ctrlWrEn || dataWrEn));
endmodule

bind gpio_port_resolver gpio_port_checker #(.PINS(PINS), .SUBS(SUBS)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrEn    (ctrlWrEn),
  .dataWrEn    (dataWrEn),
  .periphDir   (periphDir),
  .periphData  (periphData),
  .lineLevel   (lineLevel),
  .changeMask  (changeMask),
  .notify      (notify),
  .notifyLines (notifyLines)
);

// File: tb/test_gpio_port_resolver.sv
module test_gpio_port_resolver;
  localparam int PINS = 16;
  localparam int SUBS = 4;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 ctrlWrEn;
  logic [2*PINS-1:0]    ctrlWrData;
  logic                 dataWrEn;
  logic [PINS-1:0]      dataWrData;
  logic [PINS-1:0]      periphDir;
  logic [PINS-1:0]      periphData;
  logic [SUBS*PINS-1:0] trigMask;
  logic [PINS-1:0]      lineLevel;
  logic [PINS-1:0]      changeMask;
  logic [SUBS-1:0]      notify;
  logic [PINS-1:0]      notifyLines;

  int checks = 0;
  int errors = 0;

  // Reference state kept by the bench
  logic [2*PINS-1:0] mCtrl;
  logic [PINS-1:0]   mData;
  logic [PINS-1:0]   mNotifyLines;

  always #4 clk = ~clk;

  gpio_port_resolver #(.PINS(PINS), .SUBS(SUBS)) i_gpio_port_resolver (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .periphDir(periphDir), .periphData(periphData),
    .trigMask(trigMask),
    .lineLevel(lineLevel), .changeMask(changeMask),
    .notify(notify), .notifyLines(notifyLines)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] modelLines(input logic [2*PINS-1:0] c,
                                                 input logic [PINS-1:0] d);
    logic [PINS-1:0] r;
    for (int n = 0; n < PINS; n++) begin
      logic dir, pull;
      dir  = c[2*n];
      pull = c[2*n+1];
      r[n] = (dir & d[n]) | (periphDir[n] & periphData[n]) |
             (pull & ~(dir | periphDir[n]));
    end
    return r;
  endfunction

  function automatic logic [SUBS-1:0] modelNotify(input logic [PINS-1:0] chg);
    logic [SUBS-1:0] r;
    for (int i = 0; i < SUBS; i++) r[i] = (trigMask[i*PINS +: PINS] & chg) != '0;
    return r;
  endfunction

  // One write (control, data or both), checked in the cycle after the edge.
  task automatic doWrite(input bit wc, input logic [2*PINS-1:0] cv,
                         input bit wd, input logic [PINS-1:0] dv, input string req);
    logic [PINS-1:0] oldL, newL, chg;
    oldL = modelLines(mCtrl, mData);
    if (wc) mCtrl = cv;
    if (wd) mData = dv;
    newL = modelLines(mCtrl, mData);
    chg  = oldL ^ newL;
    if (chg != '0) mNotifyLines = newL;
    @(negedge clk);
    ctrlWrEn = wc; ctrlWrData = cv; dataWrEn = wd; dataWrData = dv;
    @(negedge clk);
    ctrlWrEn = 1'b0; dataWrEn = 1'b0;
    check(lineLevel == newL, req, "lineLevel", 32'(lineLevel), 32'(newL));
    check(changeMask == chg, req, "changeMask", 32'(changeMask), 32'(chg));
    check(notify == modelNotify(chg), req, "notify", 32'(notify), 32'(modelNotify(chg)));
    check(notifyLines == mNotifyLines, req, "notifyLines", 32'(notifyLines), 32'(mNotifyLines));
    @(negedge clk);
    check(changeMask == '0 && notify == '0, req, "one-cycle pulse",
          32'({notify, changeMask}), 32'd0);
  endtask

  task automatic testReset();  // R8
    check(lineLevel == '0, "R8", "reset lines", 32'(lineLevel), 32'd0);
    check(changeMask == '0, "R8", "reset changeMask", 32'(changeMask), 32'd0);
    check(notify == '0, "R8", "reset notify", 32'(notify), 32'd0);
  endtask

  task automatic testLatchHidden();  // R3, R5
    doWrite(1'b0, '0, 1'b1, 16'hFFFF, "R5");
    check(lineLevel == 16'h0000, "R3", "latch hidden while input", 32'(lineLevel), 32'd0);
  endtask

  task automatic testDirection();  // R1, R2, R4, R6
    doWrite(1'b1, 32'h0000_5555, 1'b0, '0, "R4");
    check(lineLevel == 16'h00FF, "R1", "direction bits", 32'(lineLevel), 32'h00FF);
  endtask

  task automatic testPullup();  // R1, R2, R6
    doWrite(1'b1, 32'hAAAA_5555, 1'b0, '0, "R6");
    check(lineLevel == 16'hFFFF, "R1", "pull-up bits", 32'(lineLevel), 32'hFFFF);
  endtask

  task automatic testPeriph();  // R9, R2
    @(negedge clk);
    periphDir = 16'hF000; periphData = 16'h0000;
    #1;
    check(lineLevel == 16'h0FFF, "R2", "peripheral overrides pull-up",
          32'(lineLevel), 32'h0FFF);
    @(negedge clk);
    check(changeMask == '0 && notify == '0, "R9", "no notify on periph change",
          32'({notify, changeMask}), 32'd0);
    doWrite(1'b0, '0, 1'b1, 16'hFF0F, "R7");
    @(negedge clk);
    periphDir = 16'h0000;
    @(negedge clk);
    check(notify == '0, "R9", "no notify on periph release", 32'(notify), 32'd0);
  endtask

  task automatic testSinglePull();  // R1
    doWrite(1'b1, 32'h0000_0080, 1'b0, '0, "R1");
    check(lineLevel == 16'h0008, "R1", "pull-up on pin 3 only", 32'(lineLevel), 32'h0008);
  endtask

  task automatic testBoth();  // R10
    doWrite(1'b1, 32'h5555_0000, 1'b1, 16'hA5A5, "R10");
    doWrite(1'b1, 32'h0000_0080, 1'b1, 16'h0008, "R10");
  endtask

  initial begin
    fork
      begin
        rstN = 1'b0; ctrlWrEn = 1'b0; dataWrEn = 1'b0;
        ctrlWrData = '0; dataWrData = '0;
        periphDir = '0; periphData = '0;
        trigMask = {16'hFFFF, 16'hFF00, 16'h00F0, 16'h0001};
        mCtrl = '0; mData = '0; mNotifyLines = '0;
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testLatchHidden();
        testDirection();
        testPullup();
        testPeriph();
        testSinglePull();
        testBoth();
      end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule